// File: doc/BRIEF.md
# Scatter-Gather Segment Transfer Splitter

This block turns a list of scatter-gather segments into bus transfer requests. Each segment descriptor carries a byte start address, a byte length and a flag marking the final segment of the list. Both the address and the length may have any alignment. The splitter cuts every segment into requests no longer than a configurable maximum. When a segment starts off an alignment boundary, only the first request is misaligned: it runs up to the next boundary, and every later request in that segment starts aligned.

The list's total size is never given up front. The block keeps a running sum of the segment lengths it consumes. It presents that sum with a one-cycle done pulse once the final request of the list has been taken. Zero-length segments are allowed anywhere in the list. A mode input selects a simpler normalized handling for lists whose segments are known to be page-aligned. The unrestricted handling is the default and works for any list.

Top module: `sg_splitter`

## Requirements
- R1: With `mode_norm` low and ALIGN = 16, a segment whose start address has a nonzero remainder modulo 16 is issued first as one request that ends at the next 16-byte boundary. Every later request of that segment starts at an address that is a multiple of 16. A segment that already starts aligned gets no head request.
- R2: No request is longer than MAX_XFER (0x800). An aligned segment of 0x9E0 bytes becomes 0x800 bytes followed by 0x1E0 bytes.
- R3: Within a segment, the requests are issued in ascending, contiguous address order and their lengths add up exactly to the segment length. Lengths that leave a remainder of 1, 2 or 3 modulo 4 are included.
- R4: If the distance to the next boundary is no shorter than the segment length, the segment is issued as a single request of its full length.
- R5: Consecutive segments may have different misalignments. Each segment is split on its own address without error.
- R6: With `mode_norm` high, a segment is cut into MAX_XFER pieces counted from its start address, with no head request.
- R7: `req_first` is high on the first request of a list only. `req_last` is high on the final request of a list only.
- R8: A zero-length segment produces no request. If the final segment has zero length, `req_last` is carried by the preceding request. A list made only of zero-length segments produces no request but still gives the done pulse.
- R9: `total_bytes` is the sum of the lengths of all segments accepted in the current list, restarting at the list's first descriptor. `done` is high for exactly one cycle, the cycle after the final request is accepted (or after the final zero-length descriptor of a request-free list is accepted), and `total_bytes` then holds the list total.
- R10: While `req_valid` is high and `req_ready` is low, the request fields hold steady. `seg_ready` is never high while a request is being offered.
- R11: After reset, `req_valid` and `done` are low, `total_bytes` is zero and `seg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_norm | input | 1 | 1 selects normalized splitting, 0 selects unrestricted |
| seg_valid | input | 1 | Segment descriptor present |
| seg_ready | output | 1 | Descriptor taken on this cycle when seg_valid is high |
| seg_addr | input | ADDR_W | Segment byte start address |
| seg_len | input | LEN_W | Segment byte length |
| seg_last | input | 1 | Descriptor is the final one of its list |
| req_valid | output | 1 | Transfer request offered |
| req_ready | input | 1 | Consumer takes the request |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | XLEN_W | Request byte count |
| req_first | output | 1 | First request of the list |
| req_last | output | 1 | Final request of the list |
| total_bytes | output | CNT_W | Running byte total of the list |
| done | output | 1 | One-cycle pulse at list completion |

## Verification
A descriptor accepted on an edge shows up as a registered request two edges later. Each later piece of the same segment follows two edges after the previous one is taken. The final piece of a segment that is not last waits until the next descriptor becomes visible. `done` rises one edge after the final handshake. The bench does not assume a fixed latency. It samples every port shortly after the falling edge and logs each request handshake as it happens, then compares the logged pieces, flags and the total captured during the done cycle with values worked out by hand from the requirements. Hold stability and overlap of the two handshakes are watched on every cycle.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

    // Controller states of the splitter
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,   // waiting for a descriptor
        S_GEN  = 3'd1,   // computing the next piece
        S_PEEK = 3'd2,   // final piece of a segment held, looking at the next descriptor
        S_SEND = 3'd3,   // request offered downstream
        S_DONE = 3'd4    // list completion pulse
    } sgs_state_e;

endpackage

// File: rtl/sgs_piece_calc.sv
// Length of the next piece of a segment, given its current address and remaining bytes.
module sgs_piece_calc #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int ALIGN    = 16,
    parameter int MAX_XFER = 2048,
    parameter int XLEN_W   = $clog2(MAX_XFER) + 1
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  rem_len,
    input  logic              norm,
    output logic [XLEN_W-1:0] piece_len
);
    localparam int OFF_W = $clog2(ALIGN);

    logic [OFF_W-1:0] off;
    logic [LEN_W-1:0] lim;
    logic [LEN_W-1:0] pick;

    always_comb begin
        off = cur_addr[OFF_W-1:0];
        if (norm || off == '0) begin
            lim = LEN_W'(MAX_XFER);
        end else begin
            // head piece stops at the next alignment boundary
            lim = LEN_W'(ALIGN) - LEN_W'(off);
        end
        pick      = (rem_len < lim) ? rem_len : lim;
        piece_len = XLEN_W'(pick);
    end

endmodule

// File: rtl/sgs_total_acc.sv
// Running byte total of a list; restarts on the first descriptor of each list.
module sgs_total_acc #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic             restart,
    input  logic [LEN_W-1:0] add_val,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] total_d, total_q;

    always_comb begin
        total_d = total_q;
        if (add_en) begin
            if (restart) total_d = CNT_W'(add_val);
            else         total_d = total_q + CNT_W'(add_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) total_q <= '0;
        else        total_q <= total_d;
    end

    assign total = total_q;

    // R9: total only moves when a descriptor is taken
    a_r9_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |=> $stable(total));

endmodule

// File: rtl/sg_splitter.sv
module sg_splitter #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int ALIGN    = 16,            // power of two, at least 2
    parameter int MAX_XFER = 2048,          // multiple of ALIGN
    parameter int CNT_W    = 32,
    parameter int XLEN_W   = $clog2(MAX_XFER) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_norm,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [ADDR_W-1:0] seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              seg_last,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [XLEN_W-1:0] req_len,
    output logic              req_first,
    output logic              req_last,
    output logic [CNT_W-1:0]  total_bytes,
    output logic              done
);
    import sgs_pkg::*;

    localparam int OFF_W = $clog2(ALIGN);

    typedef struct packed {
        sgs_state_e        st;
        logic [ADDR_W-1:0] addr;        // next byte of the current segment
        logic [LEN_W-1:0]  rem;         // bytes of the segment not yet cut
        logic              seg_last;    // current segment closes the list
        logic              list_first;  // next descriptor opens a list
        logic              first_pend;  // next request is the list's first
        logic              rv;
        logic [ADDR_W-1:0] ra;
        logic [XLEN_W-1:0] rl;
        logic              rlast;
    } sgs_regs_t;

    sgs_regs_t q, d;
    logic [XLEN_W-1:0] plen;
    logic              seg_take;

    sgs_piece_calc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN(ALIGN),
        .MAX_XFER(MAX_XFER), .XLEN_W(XLEN_W)
    ) u_piece (
        .cur_addr (q.addr),
        .rem_len  (q.rem),
        .norm     (mode_norm),
        .piece_len(plen)
    );

    always_comb begin
        d         = q;
        seg_ready = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                seg_ready = 1'b1;
                if (seg_valid) begin
                    d.list_first = 1'b0;
                    if (seg_len == '0) begin
                        // empty segment: nothing issued here, so an empty
                        // final segment means the whole list was empty
                        if (seg_last) d.st = S_DONE;
                    end else begin
                        d.addr     = seg_addr;
                        d.rem      = seg_len;
                        d.seg_last = seg_last;
                        d.st       = S_GEN;
                    end
                end
            end
            S_GEN: begin
                d.ra   = q.addr;
                d.rl   = plen;
                d.addr = q.addr + ADDR_W'(plen);
                d.rem  = q.rem - LEN_W'(plen);
                if (LEN_W'(plen) == q.rem && !q.seg_last) begin
                    // final piece of a non-final segment: hold it until the
                    // next descriptor shows whether the list ends here
                    d.rlast = 1'b0;
                    d.st    = S_PEEK;
                end else begin
                    d.rlast = (LEN_W'(plen) == q.rem) && q.seg_last;
                    d.rv    = 1'b1;
                    d.st    = S_SEND;
                end
            end
            S_PEEK: begin
                // only empty descriptors are consumed while a piece is held
                seg_ready = seg_valid && (seg_len == '0);
                if (seg_valid) begin
                    if (seg_len == '0) begin
                        if (seg_last) begin
                            d.rlast = 1'b1;
                            d.rv    = 1'b1;
                            d.st    = S_SEND;
                        end
                    end else begin
                        d.rv = 1'b1;
                        d.st = S_SEND;
                    end
                end
            end
            S_SEND: begin
                if (req_ready) begin
                    d.rv         = 1'b0;
                    d.first_pend = 1'b0;
                    if (q.rlast)          d.st = S_DONE;
                    else if (q.rem == '0) d.st = S_IDLE;
                    else                  d.st = S_GEN;
                end
            end
            S_DONE: begin
                d.st         = S_IDLE;
                d.list_first = 1'b1;
                d.first_pend = 1'b1;
                d.rlast      = 1'b0;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.st         <= S_IDLE;
            q.list_first <= 1'b1;
            q.first_pend <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign seg_take = seg_valid && seg_ready;

    sgs_total_acc #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_total (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_en (seg_take),
        .restart(q.list_first),
        .add_val(seg_len),
        .total  (total_bytes)
    );

    assign req_valid = q.rv;
    assign req_addr  = q.ra;
    assign req_len   = q.rl;
    assign req_first = q.first_pend;
    assign req_last  = q.rlast;
    assign done      = (q.st == S_DONE);

    // R2: every offered piece is non-empty and within the size limit
    a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0) && (req_len <= XLEN_W'(MAX_XFER)));

    // R10: an offered request holds until taken
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_len) && $stable(req_last));

    // R10: no descriptor is taken while a request is on offer
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !seg_ready);

    // R1: once a piece is taken with bytes left, the remainder starts aligned
    a_r1_aligned_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !mode_norm && (q.rem != '0)
            |-> q.addr[OFF_W-1:0] == '0);

    // R9: the completion pulse never coincides with an offered request
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

endmodule

// File: tb/sg_splitter_bench.sv
`timescale 1ns/1ps
module sg_splitter_bench;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int XW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_norm = 1'b0;
    logic seg_valid = 1'b0;
    logic seg_ready;
    logic [AW-1:0] seg_addr = '0;
    logic [LW-1:0] seg_len = '0;
    logic seg_last = 1'b0;
    logic req_valid;
    logic req_ready = 1'b1;
    logic [AW-1:0] req_addr;
    logic [XW-1:0] req_len;
    logic req_first, req_last;
    logic [31:0] total_bytes;
    logic done;

    always #5 clk = ~clk;

    sg_splitter u_sg_splitter (
        .clk(clk), .rst_n(rst_n), .mode_norm(mode_norm),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_first(req_first), .req_last(req_last),
        .total_bytes(total_bytes), .done(done)
    );

    int n_vec = 0, n_bad = 0;
    int n_got = 0, done_cnt = 0, stab_err = 0, ovl_err = 0;
    logic [31:0] done_total = '0;
    logic [AW-1:0] g_addr [16];
    logic [XW-1:0] g_len [16];
    logic g_first [16], g_last [16];
    logic bp_en = 1'b0;
    int bp_cnt = 0;
    logic hold_pend = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [XW-1:0] h_len = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // consumer readiness changes only at the falling edge
    always @(negedge clk) begin
        bp_cnt++;
        req_ready <= !bp_en || (bp_cnt % 3 == 0);
    end

    // monitor: samples one time unit after the falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (hold_pend && (!req_valid || req_addr != h_addr || req_len != h_len)) stab_err++;
            hold_pend = req_valid && !req_ready;
            h_addr = req_addr;
            h_len = req_len;
            if (seg_valid && seg_ready && req_valid) ovl_err++;
            if (req_valid && req_ready && n_got < 16) begin
                g_addr[n_got] = req_addr;
                g_len[n_got] = req_len;
                g_first[n_got] = req_first;
                g_last[n_got] = req_last;
                n_got++;
            end
            if (done) begin
                done_cnt++;
                done_total = total_bytes;
            end
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", wd, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic clear_log();
        n_got = 0;
        done_cnt = 0;
    endtask

    task automatic send_seg(input logic [AW-1:0] a, input logic [LW-1:0] l, input logic lst);
        @(negedge clk);
        seg_valid = 1'b1; seg_addr = a; seg_len = l; seg_last = lst;
        #1;
        while (!seg_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        seg_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    endtask

    typedef struct packed {
        logic        norm;
        logic [31:0] a;
        logic [15:0] l;
        logic [3:0]  n;
        logic [31:0] a0; logic [15:0] l0;
        logic [31:0] a1; logic [15:0] l1;
        logic [31:0] a2; logic [15:0] l2;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R2: aligned 0x9E0 split at the size limit
        '{1'b0, 32'h1000, 16'h09E0, 4'd2, 32'h1000, 16'h800, 32'h1800, 16'h1E0, 32'h0, 16'h0},
        // R1: misaligned start gets one head piece
        '{1'b0, 32'h1004, 16'h09E0, 4'd3, 32'h1004, 16'h00C, 32'h1010, 16'h800, 32'h1810, 16'h1D4},
        // R6: normalized mode, no head piece
        '{1'b1, 32'h1004, 16'h09E0, 4'd2, 32'h1004, 16'h800, 32'h1804, 16'h1E0, 32'h0, 16'h0},
        // R4: head distance exceeds length
        '{1'b0, 32'h2003, 16'h0005, 4'd1, 32'h2003, 16'h005, 32'h0, 16'h0, 32'h0, 16'h0},
        // R3: length remainder 1
        '{1'b0, 32'h3000, 16'h0801, 4'd2, 32'h3000, 16'h800, 32'h3800, 16'h001, 32'h0, 16'h0},
        // R3: length remainder 2 with a 15-byte head
        '{1'b0, 32'h3001, 16'h0802, 4'd2, 32'h3001, 16'h00F, 32'h3010, 16'h7F3, 32'h0, 16'h0},
        // R3: length remainder 3 with a 1-byte head
        '{1'b0, 32'h400F, 16'h0803, 4'd3, 32'h400F, 16'h001, 32'h4010, 16'h800, 32'h4810, 16'h002},
        // R1: aligned start, no head
        '{1'b0, 32'h5010, 16'h0010, 4'd1, 32'h5010, 16'h010, 32'h0, 16'h0, 32'h0, 16'h0},
        // R4: head distance equals length
        '{1'b0, 32'h6008, 16'h0008, 4'd1, 32'h6008, 16'h008, 32'h0, 16'h0, 32'h0, 16'h0}
    };

    function automatic logic [31:0] exp_a(input vec_t v, input int i);
        return (i == 0) ? v.a0 : (i == 1) ? v.a1 : v.a2;
    endfunction
    function automatic logic [15:0] exp_l(input vec_t v, input int i);
        return (i == 0) ? v.l0 : (i == 1) ? v.l1 : v.l2;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        chk(!req_valid, "R11 req_valid low in reset", req_valid, 0);
        chk(!done, "R11 done low in reset", done, 0);
        chk(total_bytes == 0, "R11 total zero", total_bytes, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(seg_ready, "R11 seg_ready after reset", seg_ready, 1);
        chk(!req_valid && !done, "R11 idle after reset", {req_valid, done}, 0);

        // table walk: one-segment lists
        for (int k = 0; k < NV; k++) begin
            clear_log();
            mode_norm = VECS[k].norm;
            send_seg(VECS[k].a, VECS[k].l, 1'b1);
            wait_done();
            chk(n_got == int'(VECS[k].n), $sformatf("R3 piece count v%0d", k), n_got, VECS[k].n);
            for (int i = 0; i < int'(VECS[k].n) && i < n_got; i++) begin
                chk(g_addr[i] == exp_a(VECS[k], i), $sformatf("R1 R3 R6 addr v%0d p%0d", k, i), g_addr[i], exp_a(VECS[k], i));
                chk(32'(g_len[i]) == 32'(exp_l(VECS[k], i)), $sformatf("R2 R4 len v%0d p%0d", k, i), g_len[i], exp_l(VECS[k], i));
                chk(g_first[i] == (i == 0), $sformatf("R7 first v%0d p%0d", k, i), g_first[i], i == 0);
                chk(g_last[i] == (i == int'(VECS[k].n) - 1), $sformatf("R7 last v%0d p%0d", k, i), g_last[i], i == int'(VECS[k].n) - 1);
            end
            chk(done_total == 32'(VECS[k].l), $sformatf("R9 total v%0d", k), done_total, VECS[k].l);
        end
        mode_norm = 1'b0;

        // R5 R8: varying misalignment, empty final segment
        clear_log();
        send_seg(32'h101, 16'd3, 1'b0);
        send_seg(32'h202, 16'h12, 1'b0);
        send_seg(32'h0, 16'd0, 1'b1);
        wait_done();
        chk(n_got == 3, "R5 piece count", n_got, 3);
        chk(g_addr[0] == 32'h101 && g_len[0] == 3, "R5 seg1 piece", g_addr[0], 32'h101);
        chk(g_addr[1] == 32'h202 && g_len[1] == 12'hE, "R5 seg2 head", g_addr[1], 32'h202);
        chk(g_addr[2] == 32'h210 && g_len[2] == 4, "R5 seg2 body", g_addr[2], 32'h210);
        chk(g_last[2] && !g_last[1] && !g_last[0], "R8 last moved to preceding request", {g_last[0], g_last[1], g_last[2]}, 3'b001);
        chk(g_first[0] && !g_first[1], "R7 first only once", {g_first[0], g_first[1]}, 2'b10);
        chk(done_total == 32'h15, "R9 total restarts per list", done_total, 32'h15);

        // R8: empty segments in the middle and at the start
        clear_log();
        send_seg(32'h10, 16'd0, 1'b0);
        send_seg(32'h20, 16'h10, 1'b0);
        send_seg(32'h30, 16'd0, 1'b0);
        send_seg(32'h40, 16'd1, 1'b1);
        wait_done();
        chk(n_got == 2, "R8 empty segments skipped", n_got, 2);
        chk(g_addr[0] == 32'h20 && g_first[0] && !g_last[0], "R8 first real piece", g_addr[0], 32'h20);
        chk(g_addr[1] == 32'h40 && g_len[1] == 1 && g_last[1], "R8 final piece", g_addr[1], 32'h40);
        chk(done_total == 32'h11, "R9 total with empties", done_total, 32'h11);

        // R8: list of empty segments only
        clear_log();
        send_seg(32'h0, 16'd0, 1'b0);
        send_seg(32'h0, 16'd0, 1'b1);
        wait_done();
        chk(n_got == 0, "R8 empty list gives no request", n_got, 0);
        chk(done_total == 0, "R9 empty list total", done_total, 0);

        // R10: backpressure on a misaligned split
        clear_log();
        bp_en = 1'b1;
        send_seg(32'h1004, 16'h09E0, 1'b1);
        wait_done();
        bp_en = 1'b0;
        chk(n_got == 3, "R10 count under backpressure", n_got, 3);
        chk(g_addr[1] == 32'h1010 && g_len[2] == 12'h1D4, "R10 pieces under backpressure", g_addr[1], 32'h1010);
        chk(stab_err == 0, "R10 request held while stalled", stab_err, 0);
        chk(ovl_err == 0, "R10 no descriptor taken during request", ovl_err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule